// File: doc/BRIEF.md
# Sawtooth PWM Timer with Two Compare Outputs

This block is one timer channel that produces two pulse-width-modulated outputs from a single up-counting sawtooth counter. Both outputs use the same prescaler and the same period. Each output has its own compare value and its own 5-bit action code. The action code sets three things: the level the pin starts at, what the pin does when the counter wraps at the period boundary, and what it does when the counter reaches the pin's compare value. A per-pin enable holds the pin low when it is clear.

Software programs the timer through a small word-addressed register port with a single-cycle write strobe and a combinational read. To set up a waveform, first program the period, the two compare values and the pin configuration. Then optionally preload the counter. Finally, set the start bit. The counter mode and the prescaler can only be changed while the timer is stopped.

Top module: `saw_pwm_timer`

## Requirements
- R1: After reset, every register reads 0, the counter is stopped, and both outputs are low.
- R2: Registers sit at byte offsets 0x2C (control), 0x30 (direction), 0x34 (pin configuration), 0x48 (counter), 0x4C (compare A), 0x50 (compare B) and 0x64 (period). Control bit 0 is start, bits 18:16 are mode and bits 26:24 are prescaler select. Direction keeps bits 1:0. Pin configuration keeps an action code for output A in bits 4:0 with its enable in bit 8, and an action code for output B in bits 20:16 with its enable in bit 24. Bits not listed here read as 0.
- R3: While start is 1, writes to control update only the start bit. The mode and prescaler fields keep their values.
- R4: The counter runs only while start is 1 and mode is 0. In that state it advances once every 4^S clock cycles, where S is the prescaler select. Select values above 5 behave as 5, which gives a ratio of 1024. The first advance comes 4^S cycles after the cycle in which start was written.
- R5: When the counter equals the period, the next advance sets it to 0 rather than incrementing it.
- R6: Action code bits 1:0 give the compare action: 00 hold, 01 low, 10 high, 11 toggle. The compare action is applied on the advance whose new count equals the compare value. No compare action occurs when the compare value is greater than the period.
- R7: Action code bits 3:2 give the period-end action, using the same encoding as R6. It is applied on the wrapping advance. If a compare action falls on the same advance, the compare action is applied after the period-end action.
- R8: While the counter is not running, each pin level is loaded from bit 4 of its action code. A pin therefore starts at that level when counting begins.
- R9: An output is low whenever its enable is clear or the counter is not running.
- R10: A write to the counter register changes the count only while start is 0. The register always reads the live count.
- R11: With period P and compare C ≤ P, an output using code 0x07 is high for P−C+1 of every P+1 counter steps. An output using code 0x1B is low for P−C+1 of every P+1 counter steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | ADDR_W | Byte offset of the register being accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pwm_a | output | 1 | Output driven by compare A |
| pwm_b | output | 1 | Output driven by compare B |

## Verification
The bench uses the default parameters: a 32-bit counter and an 8-bit address. The programmed periods are kept small (9 and 1) so that many full wraps happen within a short run. Prescaler selects 0, 1 and an out-of-range 7 are exercised. The 7 reaches the 1024 ratio, so the slowest tick spacing and the select clamp are both observed directly. Compare values above the period and a compare value of 0 are also exercised, the latter so that the wrap and the match fall on the same advance.

// File: rtl/pst_pkg.sv
package pst_pkg;

  localparam int unsigned PSC_SEL_MAX = 5;
  localparam int unsigned PSC_W       = 2 * PSC_SEL_MAX + 1;

  localparam int unsigned OFS_CTRL = 32'h2C;
  localparam int unsigned OFS_DIR  = 32'h30;
  localparam int unsigned OFS_PIN  = 32'h34;
  localparam int unsigned OFS_CNT  = 32'h48;
  localparam int unsigned OFS_CMPA = 32'h4C;
  localparam int unsigned OFS_CMPB = 32'h50;
  localparam int unsigned OFS_PER  = 32'h64;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } pin_act_e;

  // Level after applying a 2-bit pin action to the present level.
  function automatic logic apply_act(input logic [1:0] act, input logic lvl);
    case (pin_act_e'(act))
      ACT_HOLD:   return lvl;
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      default:    return ~lvl;
    endcase
  endfunction

  // Prescaler select limited to the largest legal value.
  function automatic logic [2:0] clamp_sel(input logic [2:0] sel);
    return (sel > 3'(PSC_SEL_MAX)) ? 3'(PSC_SEL_MAX) : sel;
  endfunction

  // Terminal value of the prescaler divider: 4^sel - 1.
  function automatic logic [PSC_W-1:0] psc_last(input logic [2:0] sel);
    logic [PSC_W-1:0] ratio;
    ratio = PSC_W'(1) << (2 * clamp_sel(sel));
    return ratio - PSC_W'(1);
  endfunction

endpackage

// File: rtl/pst_regs.sv
module pst_regs
  import pst_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [CNT_W-1:0]  cnt_live,
  output logic [31:0]       rdata,
  output logic              start,
  output logic [2:0]        mode,
  output logic [2:0]        psc_sel,
  output logic [1:0][4:0]   pin_act,
  output logic [1:0]        pin_en,
  output logic [1:0][CNT_W-1:0] cmp,
  output logic [CNT_W-1:0]  period,
  output logic              cnt_we,
  output logic [CNT_W-1:0]  cnt_wval
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_PIN  = ADDR_W'(OFS_PIN);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(OFS_CNT);
  localparam logic [ADDR_W-1:0] A_CMPA = ADDR_W'(OFS_CMPA);
  localparam logic [ADDR_W-1:0] A_CMPB = ADDR_W'(OFS_CMPB);
  localparam logic [ADDR_W-1:0] A_PER  = ADDR_W'(OFS_PER);

  logic [1:0] dir_q;

  // Counter preload only while stopped (R10)
  assign cnt_we   = we && (addr == A_CNT) && !start;
  assign cnt_wval = wdata[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start   <= 1'b0;
      mode    <= '0;
      psc_sel <= '0;
      dir_q   <= '0;
      pin_act <= '0;
      pin_en  <= '0;
      cmp     <= '0;
      period  <= '0;
    end else if (we) begin
      case (addr)
        A_CTRL: begin
          start <= wdata[0];
          if (!start) begin
            mode    <= wdata[18:16];
            psc_sel <= wdata[26:24];
          end
        end
        A_DIR:  dir_q <= wdata[1:0];
        A_PIN: begin
          pin_act[0] <= wdata[4:0];
          pin_en[0]  <= wdata[8];
          pin_act[1] <= wdata[20:16];
          pin_en[1]  <= wdata[24];
        end
        A_CMPA: cmp[0] <= wdata[CNT_W-1:0];
        A_CMPB: cmp[1] <= wdata[CNT_W-1:0];
        A_PER:  period <= wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[0]     = start;
        rdata[18:16] = mode;
        rdata[26:24] = psc_sel;
      end
      A_DIR:  rdata[1:0] = dir_q;
      A_PIN: begin
        rdata[4:0]   = pin_act[0];
        rdata[8]     = pin_en[0];
        rdata[20:16] = pin_act[1];
        rdata[24]    = pin_en[1];
      end
      A_CNT:  rdata = 32'(cnt_live);
      A_CMPA: rdata = 32'(cmp[0]);
      A_CMPB: rdata = 32'(cmp[1]);
      A_PER:  rdata = 32'(period);
      default: rdata = '0;
    endcase
  end

  // R3
  cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ($stable(mode) && $stable(psc_sel)));

endmodule

// File: rtl/pst_prescaler.sv
module pst_prescaler
  import pst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       tick
);

  logic [PSC_W-1:0] div_q;

  assign tick = run && (div_q == psc_last(sel));

  always_ff @(posedge clk) begin
    if (!rst_n)       div_q <= '0;
    else if (!run)    div_q <= '0;
    else if (tick)    div_q <= '0;
    else              div_q <= div_q + PSC_W'(1);
  end

  // R4
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (sel != 3'd0)) |=> !tick);

endmodule

// File: rtl/pst_counter.sv
module pst_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_next,
  output logic             wrap_evt
);

  logic at_end;

  assign at_end   = (cnt == period);
  assign cnt_next = at_end ? '0 : cnt + CNT_W'(1);
  assign wrap_evt = tick && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= load_val;
    else if (tick)  cnt <= cnt_next;
  end

  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_evt && !load) |=> (cnt == '0));

  // R10
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt));

endmodule

// File: rtl/pst_pin.sv
module pst_pin
  import pst_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             wrap_evt,
  input  logic [CNT_W-1:0] cnt_next,
  input  logic [CNT_W-1:0] cmp,
  input  logic [CNT_W-1:0] period,
  input  logic [4:0]       act,
  input  logic             en,
  output logic             match_evt,
  output logic             pin_out
);

  logic lvl_q;
  logic lvl_end;
  logic lvl_new;

  assign match_evt = tick && (cmp <= period) && (cnt_next == cmp);
  assign lvl_end   = wrap_evt ? apply_act(act[3:2], lvl_q) : lvl_q;
  assign lvl_new   = match_evt ? apply_act(act[1:0], lvl_end) : lvl_end;

  always_ff @(posedge clk) begin
    if (!rst_n)     lvl_q <= 1'b0;
    else if (!run)  lvl_q <= act[4];
    else if (tick)  lvl_q <= lvl_new;
  end

  assign pin_out = run && en && lvl_q;

  // R8
  init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (lvl_q == $past(act[4])));

  // R6
  lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(lvl_q));

endmodule

// File: rtl/saw_pwm_timer.sv
module saw_pwm_timer
  import pst_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              pwm_a,
  output logic              pwm_b
);

  localparam int unsigned NPIN = 2;

  logic                     start;
  logic [2:0]               mode;
  logic [2:0]               psc_sel;
  logic [NPIN-1:0][4:0]     pin_act;
  logic [NPIN-1:0]          pin_en;
  logic [NPIN-1:0][CNT_W-1:0] cmp;
  logic [CNT_W-1:0]         period;
  logic                     cnt_we;
  logic [CNT_W-1:0]         cnt_wval;
  logic [CNT_W-1:0]         cnt;
  logic [CNT_W-1:0]         cnt_next;
  logic                     wrap_evt;
  logic                     tick;
  logic                     running;
  logic [NPIN-1:0]          match_evt;
  logic [NPIN-1:0]          pin_out;

  // Only mode 0 (sawtooth) counts
  assign running = start && (mode == 3'd0);

  pst_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .cnt_live(cnt), .rdata(bus_rdata), .start(start), .mode(mode),
    .psc_sel(psc_sel), .pin_act(pin_act), .pin_en(pin_en), .cmp(cmp),
    .period(period), .cnt_we(cnt_we), .cnt_wval(cnt_wval)
  );

  pst_prescaler u_psc (
    .clk(clk), .rst_n(rst_n), .run(running), .sel(psc_sel), .tick(tick)
  );

  pst_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .period(period),
    .load(cnt_we), .load_val(cnt_wval),
    .cnt(cnt), .cnt_next(cnt_next), .wrap_evt(wrap_evt)
  );

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    pst_pin #(.CNT_W(CNT_W)) u_pin (
      .clk(clk), .rst_n(rst_n), .run(running), .tick(tick),
      .wrap_evt(wrap_evt), .cnt_next(cnt_next), .cmp(cmp[p]),
      .period(period), .act(pin_act[p]), .en(pin_en[p]),
      .match_evt(match_evt[p]), .pin_out(pin_out[p])
    );
  end

  assign pwm_a = pin_out[0];
  assign pwm_b = pin_out[1];

  // R9
  off_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(start) |-> (!pwm_a && !pwm_b));

  // R6
  match_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt != '0) |-> tick);

endmodule

// File: tb/saw_pwm_timer_bench.sv
module saw_pwm_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwm_a, pwm_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  saw_pwm_timer u_saw_pwm_timer (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_a(pwm_a), .pwm_b(pwm_b)
  );

  // ---------------- behavioural reference model ----------------
  bit          m_start;
  int          m_mode, m_psc, m_div;
  bit [4:0]    m_act [2];
  bit          m_en  [2];
  bit          m_lvl [2];
  bit [31:0]   m_cmp [2];
  bit [31:0]   m_per, m_cnt;

  function automatic bit act_fn(bit [1:0] a, bit l);
    if (a == 2'd0) return l;
    if (a == 2'd1) return 1'b0;
    if (a == 2'd2) return 1'b1;
    return !l;
  endfunction

  function automatic bit m_run();
    return m_start && (m_mode == 0);
  endfunction

  always @(posedge clk) begin
    bit run, tick, at_end, wr_ok;
    int ratio, s;
    bit [31:0] nxt;
    if (!rst_n) begin
      m_start = 0; m_mode = 0; m_psc = 0; m_div = 0;
      m_per = 0; m_cnt = 0;
      for (int p = 0; p < 2; p++) begin
        m_act[p] = 0; m_en[p] = 0; m_lvl[p] = 0; m_cmp[p] = 0;
      end
    end else begin
      run   = m_run();
      s     = (m_psc > 5) ? 5 : m_psc;
      ratio = 1 << (2 * s);
      tick  = run && (m_div == ratio - 1);
      at_end = (m_cnt == m_per);
      nxt   = at_end ? 32'd0 : m_cnt + 32'd1;
      for (int p = 0; p < 2; p++) begin
        if (!run) m_lvl[p] = m_act[p][4];
        else if (tick) begin
          if (at_end) m_lvl[p] = act_fn(m_act[p][3:2], m_lvl[p]);
          if (m_cmp[p] <= m_per && nxt == m_cmp[p])
            m_lvl[p] = act_fn(m_act[p][1:0], m_lvl[p]);
        end
      end
      m_div = (!run || tick) ? 0 : m_div + 1;
      wr_ok = bus_we && bus_addr == 8'h48 && !m_start;
      if (wr_ok) m_cnt = bus_wdata;
      else if (tick) m_cnt = nxt;
      if (bus_we) begin
        case (bus_addr)
          8'h2C: begin
            if (!m_start) begin
              m_mode = int'(bus_wdata[18:16]);
              m_psc  = int'(bus_wdata[26:24]);
            end
            m_start = bus_wdata[0];
          end
          8'h34: begin
            m_act[0] = bus_wdata[4:0];   m_en[0] = bus_wdata[8];
            m_act[1] = bus_wdata[20:16]; m_en[1] = bus_wdata[24];
          end
          8'h4C: m_cmp[0] = bus_wdata;
          8'h50: m_cmp[1] = bus_wdata;
          8'h64: m_per = bus_wdata;
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison of both outputs against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (pwm_a !== (m_run() && m_en[0] && m_lvl[0])) begin
        errors++;
        $display("FAIL R9 cycle pwm_a act=%0b exp=%0b", pwm_a, m_run() && m_en[0] && m_lvl[0]);
      end
      checks++;
      if (pwm_b !== (m_run() && m_en[1] && m_lvl[1])) begin
        errors++;
        $display("FAIL R9 cycle pwm_b act=%0b exp=%0b", pwm_b, m_run() && m_en[1] && m_lvl[1]);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic count_level(input int which, input bit lvl, input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (((which == 0) ? pwm_a : pwm_b) == lvl) cnt++;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  // ---------------- directed sequence ----------------
  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h2C, d); chk("R1 ctrl", d, 32'h0);
    rd(8'h48, d); chk("R1 counter", d, 32'h0);
    rd(8'h64, d); chk("R1 period", d, 32'h0);
    chk("R1 pwm_a", {31'd0, pwm_a}, 32'd0);

    // R2 field placement
    wr(8'h34, 32'hFFFF_FFFF); rd(8'h34, d); chk("R2 pincfg", d, 32'h011F_011F);
    wr(8'h30, 32'hFFFF_FFFF); rd(8'h30, d); chk("R2 dir", d, 32'h3);
    wr(8'h2C, 32'hFFFF_FFFE); rd(8'h2C, d); chk("R2 ctrl", d, 32'h0707_0000);
    wr(8'h2C, 32'h0); rd(8'h2C, d); chk("R2 ctrl clear", d, 32'h0);
    wr(8'h4C, 32'h1234_5678); rd(8'h4C, d); chk("R2 cmpA", d, 32'h1234_5678);

    // R10 counter preload while stopped
    wr(8'h48, 32'd7); rd(8'h48, d); chk("R10 preload", d, 32'd7);

    // Basic waveform: period 9, A=3 code 0x07, B=6 code 0x1B
    wr(8'h64, 32'd9); wr(8'h4C, 32'd3); wr(8'h50, 32'd6);
    wr(8'h34, 32'h011B_0107); wr(8'h48, 32'd0);
    wr(8'h2C, 32'h1);
    // R8: B starts high right after start
    chk("R8 init level B", {31'd0, pwm_b}, 32'd1);
    idle(5);
    count_level(0, 1'b1, 10, n); chk("R11 A high ticks", n, 32'd7);
    count_level(1, 1'b0, 10, n); chk("R11 B low ticks", n, 32'd4);
    count_level(0, 1'b1, 30, n); chk("R11 A high 3 periods", n, 32'd21);

    // R10 write while running ignored
    wr(8'h48, 32'd100); rd(8'h48, d); chk("R10 running write ignored", {31'd0, d <= 32'd9}, 32'd1);
    chk("R10 live count", d, m_cnt);
    // R3 config lock
    wr(8'h2C, 32'h0201_0001); rd(8'h2C, d); chk("R3 lock", d, 32'h1);

    // R9 enable clear
    wr(8'h34, 32'h011B_0007);
    count_level(0, 1'b1, 20, n); chk("R9 A disabled", n, 32'd0);

    // stop -> outputs low
    wr(8'h2C, 32'h0);
    chk("R9 stopped A", {31'd0, pwm_a}, 32'd0);
    chk("R9 stopped B", {31'd0, pwm_b}, 32'd0);

    // R4 prescaler 4
    wr(8'h34, 32'h011B_0107); wr(8'h48, 32'd0);
    wr(8'h2C, 32'h0100_0000); wr(8'h2C, 32'h0100_0001);
    idle(3);
    count_level(0, 1'b1, 40, n); chk("R4 A high at div4", n, 32'd28);
    wr(8'h2C, 32'h0);

    // R6 compare beyond period, R7 compare at 0 with wrap
    wr(8'h4C, 32'd20); wr(8'h50, 32'd0); wr(8'h48, 32'd0);
    wr(8'h2C, 32'h1);
    idle(12);
    count_level(0, 1'b1, 20, n); chk("R6 no match above period", n, 32'd0);
    count_level(1, 1'b1, 20, n); chk("R7 end then match same tick", n, 32'd0);
    rd(8'h48, d); chk("R5 count within period", {31'd0, d <= 32'd9}, 32'd1);
    wr(8'h2C, 32'h0);

    // R4 mode nonzero does not count
    wr(8'h48, 32'd0); wr(8'h2C, 32'h0001_0001);
    idle(10);
    rd(8'h48, d); chk("R4 mode1 frozen", d, 32'd0);
    chk("R9 mode1 low", {31'd0, pwm_b}, 32'd0);
    wr(8'h2C, 32'h0);

    // R4 select clamp: 7 acts as 1024, R5 wrap at period 1
    wr(8'h64, 32'd1); wr(8'h48, 32'd0);
    wr(8'h2C, 32'h0700_0000); rd(8'h2C, d); chk("R2 raw select kept", d, 32'h0700_0000);
    wr(8'h2C, 32'h0700_0001);
    idle(1000);
    rd(8'h48, d); chk("R4 before 1024", d, 32'd0);
    idle(30);
    rd(8'h48, d); chk("R4 after 1024", d, 32'd1);
    idle(1030);
    rd(8'h48, d); chk("R5 wrap to 0", d, 32'd0);
    wr(8'h2C, 32'h0);

    idle(4);
    finish_run();
  end

endmodule